// File: doc/BRIEF.md
# Warp Lane Shuffle Unit

This block exchanges 32-bit values among the 32 lanes of a SIMT execution group in a single step. Every lane presents one data word. One shared control word and one shared offset/index operand then decide, for each lane, which other lane it reads from. Each of these two operands is taken either from an immediate field or from a register operand, and a separate select bit chooses for each. There are four ways of forming the source lane: a direct index, a shift toward lower lanes ("up"), a shift toward higher lanes ("down"), and an XOR pattern ("butterfly").

The control word can split the group into sub-groups (segments). Two of its fields set the segment: a clamp field, which bounds the highest reachable lane inside a segment, and a segment-mask field, which picks the lane-number bits that identify the segment. For every lane the block also produces an in-bounds flag. A lane whose flag is clear keeps its own value. The result vector and the flags are registered and appear one cycle after a valid strobe, together with a one-cycle valid-out pulse.

Top module: `lane_xchg_unit`

## Requirements
- R1: While reset is asserted and after it is released, before any strobe, `out_valid`, `out_pred` and `out_data` are all zero.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. Outputs from a strobe appear in that same cycle.
- R3: The control word is `mask_imm` when `mask_use_imm`=1 and `mask_reg` otherwise. The offset/index is `idx_imm` when `idx_use_imm`=1 and `idx_reg` otherwise.
- R4: The clamp value is bits [4:0] of the control word. The segment mask is bits [23:8] of the control word, zero-extended. For lane L, the segment minimum is L AND segmask. The segment maximum is that minimum OR (clamp AND NOT segmask).
- R5: With `mode`=0 (indexed), the source lane is (index AND NOT segmask) OR the segment minimum, and the flag is source ≤ segment maximum.
- R6: With `mode`=1 (up), the source lane is L − index, and the flag is source ≥ segment minimum. Both values are compared as signed 32-bit numbers, so a source below zero fails.
- R7: With `mode`=2 (down), the source lane is L + index, and the flag is source ≤ segment maximum, compared as signed 32-bit numbers.
- R8: With `mode`=3 (butterfly), the source lane is L XOR index, and the flag is source ≤ segment maximum, compared as signed 32-bit numbers.
- R9: Lane L's output word is the input word of lane (source[4:0]) when its flag is set, and its own input word when its flag is clear. `out_pred` bit L is the flag.
- R10: In a cycle without a strobe, `out_data` and `out_pred` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Strobe: one shuffle in this cycle |
| mode | input | 2 | 0 indexed, 1 up, 2 down, 3 butterfly |
| mask_use_imm | input | 1 | 1 selects mask_imm as control word |
| mask_imm | input | 32 | Immediate control word |
| mask_reg | input | 32 | Register control word |
| idx_use_imm | input | 1 | 1 selects idx_imm as offset/index |
| idx_imm | input | 32 | Immediate offset/index |
| idx_reg | input | 32 | Register offset/index |
| lane_data | input | 1024 | Lane L word at bits [32L+31:32L] |
| out_valid | output | 1 | Result pulse |
| out_pred | output | 32 | Per-lane in-bounds flag |
| out_data | output | 1024 | Per-lane result, same packing as lane_data |

## Verification
The bounds check and the crossbar selection act in the same cycle for the same lane. A flag that fails must replace the crossbar result with the lane's own word, even when the wrapped source number [4:0] would pick a real lane. The sweep provokes this by running every mode over offsets 0 to 33, an all-ones offset and a sign-bit-only offset, under several segment layouts. Many lanes then land out of bounds, including lanes whose up-mode source is negative. Each result word and flag is compared with values computed arithmetically from the segment formulas.

// File: rtl/lxu_pkg.sv
`timescale 1ns/1ps
package lxu_pkg;

    typedef enum logic [1:0] {
        SH_IDX  = 2'd0,
        SH_UP   = 2'd1,
        SH_DOWN = 2'd2,
        SH_BFLY = 2'd3
    } shfl_mode_e;

    localparam int SEG_LSB = 8;
    localparam int SEG_W   = 16;

endpackage

// File: rtl/lxu_operand_sel.sv
`timescale 1ns/1ps
// R3: picks the control word and the offset/index from immediate or register.
module lxu_operand_sel #(
    parameter int CW = 32
) (
    input  logic          mask_use_imm,
    input  logic [CW-1:0] mask_imm,
    input  logic [CW-1:0] mask_reg,
    input  logic          idx_use_imm,
    input  logic [CW-1:0] idx_imm,
    input  logic [CW-1:0] idx_reg,
    output logic [CW-1:0] mask_sel,
    output logic [CW-1:0] idx_sel
);

    always_comb begin
        mask_sel = mask_use_imm ? mask_imm : mask_reg;
        idx_sel  = idx_use_imm  ? idx_imm  : idx_reg;
    end

endmodule

// File: rtl/lxu_lane_calc.sv
`timescale 1ns/1ps
// Source-lane arithmetic and bounds flag for one lane (R4..R8).
module lxu_lane_calc
    import lxu_pkg::*;
#(
    parameter int CW      = 32,
    parameter int LW      = 5,
    parameter int LANE_ID = 0
) (
    input  shfl_mode_e    mode,
    input  logic [CW-1:0] mask,
    input  logic [CW-1:0] idx,
    output logic [LW-1:0] src_lane,
    output logic          in_bounds
);

    localparam logic [CW-1:0] LID     = CW'(LANE_ID);
    localparam logic [CW-1:0] CLAMP_M = CW'((1 << LW) - 1);
    localparam logic [CW-1:0] SEG_M   = CW'((1 << SEG_W) - 1);

    logic [CW-1:0] clamp_v;
    logic [CW-1:0] seg_v;
    logic [CW-1:0] seg_min;
    logic [CW-1:0] seg_max;
    logic [CW-1:0] src_v;

    always_comb begin
        // R4: segment fields and bounds
        clamp_v = mask & CLAMP_M;
        seg_v   = (mask >> SEG_LSB) & SEG_M;
        seg_min = LID & seg_v;
        seg_max = seg_min | (clamp_v & ~seg_v);

        unique case (mode)
            SH_IDX:  src_v = (idx & ~seg_v) | seg_min;   // R5
            SH_UP:   src_v = LID - idx;                  // R6
            SH_DOWN: src_v = LID + idx;                  // R7
            default: src_v = LID ^ idx;                  // R8
        endcase

        if (mode == SH_UP)
            in_bounds = $signed(src_v) >= $signed(seg_min);
        else
            in_bounds = $signed(src_v) <= $signed(seg_max);

        src_lane = src_v[LW-1:0];
    end

endmodule

// File: rtl/lxu_xbar.sv
`timescale 1ns/1ps
// R9: combinational crossbar with own-value fallback.
module lxu_xbar #(
    parameter int LANES = 32,
    parameter int DW    = 32,
    parameter int LW    = $clog2(LANES)
) (
    input  logic [LANES*DW-1:0] din,
    input  logic [LANES*LW-1:0] src,
    input  logic [LANES-1:0]    hit,
    output logic [LANES*DW-1:0] dout
);

    always_comb begin
        for (int l = 0; l < LANES; l++) begin
            if (hit[l])
                dout[l*DW +: DW] = din[int'(src[l*LW +: LW])*DW +: DW];
            else
                dout[l*DW +: DW] = din[l*DW +: DW];
        end
    end

endmodule

// File: rtl/lane_xchg_unit.sv
`timescale 1ns/1ps
module lane_xchg_unit
    import lxu_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DW    = 32,
    parameter int CW    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [1:0]          mode,
    input  logic                mask_use_imm,
    input  logic [CW-1:0]       mask_imm,
    input  logic [CW-1:0]       mask_reg,
    input  logic                idx_use_imm,
    input  logic [CW-1:0]       idx_imm,
    input  logic [CW-1:0]       idx_reg,
    input  logic [LANES*DW-1:0] lane_data,
    output logic                out_valid,
    output logic [LANES-1:0]    out_pred,
    output logic [LANES*DW-1:0] out_data
);

    localparam int LW = $clog2(LANES);

    typedef struct packed {
        logic                vld;
        logic [LANES-1:0]    pred;
        logic [LANES*DW-1:0] data;
    } stage_t;

    stage_t st_d, st_q;

    logic [CW-1:0]       mask_sel;
    logic [CW-1:0]       idx_sel;
    logic [LANES*LW-1:0] src_w;
    logic [LANES-1:0]    pred_w;
    logic [LANES*DW-1:0] xbar_w;
    shfl_mode_e          mode_e;

    assign mode_e = shfl_mode_e'(mode);

    lxu_operand_sel #(.CW(CW)) opsel_i (
        .mask_use_imm (mask_use_imm),
        .mask_imm     (mask_imm),
        .mask_reg     (mask_reg),
        .idx_use_imm  (idx_use_imm),
        .idx_imm      (idx_imm),
        .idx_reg      (idx_reg),
        .mask_sel     (mask_sel),
        .idx_sel      (idx_sel)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lxu_lane_calc #(.CW(CW), .LW(LW), .LANE_ID(g)) calc_i (
            .mode      (mode_e),
            .mask      (mask_sel),
            .idx       (idx_sel),
            .src_lane  (src_w[g*LW +: LW]),
            .in_bounds (pred_w[g])
        );
    end

    lxu_xbar #(.LANES(LANES), .DW(DW), .LW(LW)) xbar_i (
        .din  (lane_data),
        .src  (src_w),
        .hit  (pred_w),
        .dout (xbar_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;          // R2
        if (in_valid) begin
            st_d.pred = pred_w;
            st_d.data = xbar_w;
        end                           // R10: hold otherwise
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;       // R1
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_pred  = st_q.pred;
    assign out_data  = st_q.data;

    a_r2_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_data) && $stable(out_pred) && !out_valid);

    a_r6_up_zero_in_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && mode_e == SH_UP && idx_sel == '0 |=> &out_pred);

    a_r8_bfly_zero_identity: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && mode_e == SH_BFLY && idx_sel == '0 |=> out_data == $past(lane_data));

    for (genvar g = 0; g < LANES; g++) begin : g_chk
        a_r9_own_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid && !out_pred[g] |-> out_data[g*DW +: DW] == $past(lane_data[g*DW +: DW]));
    end

endmodule

// File: tb/lane_xchg_unit_tb_top.sv
`timescale 1ns/1ps
module lane_xchg_unit_tb_top;

    localparam int LANES = 32;
    localparam int DW    = 32;
    localparam int CW    = 32;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic                rst_n = 1'b0;
    logic                in_valid = 1'b0;
    logic [1:0]          mode = '0;
    logic                mask_use_imm = 1'b0;
    logic [CW-1:0]       mask_imm = '0;
    logic [CW-1:0]       mask_reg = '0;
    logic                idx_use_imm = 1'b0;
    logic [CW-1:0]       idx_imm = '0;
    logic [CW-1:0]       idx_reg = '0;
    logic [LANES*DW-1:0] lane_data = '0;
    logic                out_valid;
    logic [LANES-1:0]    out_pred;
    logic [LANES*DW-1:0] out_data;

    lane_xchg_unit #(.LANES(LANES), .DW(DW), .CW(CW)) dut_i (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .mode (mode),
        .mask_use_imm (mask_use_imm), .mask_imm (mask_imm), .mask_reg (mask_reg),
        .idx_use_imm (idx_use_imm), .idx_imm (idx_imm), .idx_reg (idx_reg),
        .lane_data (lane_data), .out_valid (out_valid), .out_pred (out_pred),
        .out_data (out_data)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 0;

    task automatic check(input bit ok, input string req, input logic [LANES*DW-1:0] act,
                         input logic [LANES*DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'd0:    return "R5";
            2'd1:    return "R6";
            2'd2:    return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic model(input logic [1:0] m, input logic [31:0] mk, input logic [31:0] ix,
                         input logic [LANES*DW-1:0] din,
                         output logic [LANES*DW-1:0] eo, output logic [LANES-1:0] ep);
        logic [31:0] cl, sg, mn, mx, s, lid;
        for (int l = 0; l < LANES; l++) begin
            lid = 32'(l);
            cl  = mk & 32'h1F;
            sg  = (mk >> 8) & 32'hFFFF;
            mn  = lid & sg;
            mx  = mn | (cl & ~sg);
            case (m)
                2'd0:    s = (ix & ~sg) | mn;
                2'd1:    s = lid - ix;
                2'd2:    s = lid + ix;
                default: s = lid ^ ix;
            endcase
            ep[l] = (m == 2'd1) ? ($signed(s) >= $signed(mn)) : ($signed(s) <= $signed(mx));
            eo[l*DW +: DW] = ep[l] ? din[int'(s[4:0])*DW +: DW] : din[l*DW +: DW];
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 190000 && !done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected<190000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    logic [31:0] masks [6];
    initial begin
        logic [LANES*DW-1:0] eo, prev_d;
        logic [LANES-1:0]    ep, prev_p;
        logic [31:0]         ix;
        int                  vec;
        masks[0] = 32'h0000_001F;   // one full segment
        masks[1] = 32'h0000_1807;   // segments of 8
        masks[2] = 32'h0000_1C03;   // segments of 4
        masks[3] = 32'h0000_0000;   // clamp 0, no segment bits
        masks[4] = 32'h0000_1F00;   // single-lane segments
        masks[5] = 32'hFFFF_FFFF;   // all field bits and upper bits set
        vec = 0;

        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && out_pred == '0 && out_data == '0, "R1 in reset",
              out_data, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0 && out_pred == '0 && out_data == '0, "R1 after release",
              {out_valid, out_pred}, '0);

        for (int m = 0; m < 4; m++) begin
            for (int k = 0; k < 6; k++) begin
                for (int j = 0; j < 36; j++) begin
                    ix = (j < 34) ? 32'(j) : ((j == 34) ? 32'hFFFF_FFFF : 32'h8000_0000);
                    for (int l = 0; l < LANES; l++)
                        lane_data[l*DW +: DW] = 32'hA500_0000 ^ (32'(l) * 32'h0101_0101) ^ 32'(vec << 8);
                    mode         = 2'(m);
                    mask_use_imm = vec[0];
                    idx_use_imm  = vec[1];
                    mask_imm     = vec[0] ? masks[k] : ~masks[k];
                    mask_reg     = vec[0] ? ~masks[k] : masks[k];
                    idx_imm      = vec[1] ? ix : ix ^ 32'h0000_0015;
                    idx_reg      = vec[1] ? ix ^ 32'h0000_0015 : ix;
                    model(2'(m), masks[k], ix, lane_data, eo, ep);
                    in_valid = 1'b1;
                    @(negedge clk);
                    in_valid = 1'b0;
                    check(out_valid == 1'b1, "R2 pulse", {1023'b0, out_valid}, 1);
                    check(out_pred == ep, {mode_tag(2'(m)), " R4 R3 flags"},
                          {992'b0, out_pred}, {992'b0, ep});
                    check(out_data == eo, {mode_tag(2'(m)), " R9 R3 data"}, out_data, eo);
                    prev_d = out_data;
                    prev_p = out_pred;
                    lane_data = ~lane_data;
                    mode      = mode + 2'd1;
                    @(negedge clk);
                    check(out_valid == 1'b0, "R2 single pulse", {1023'b0, out_valid}, 0);
                    check(out_data == prev_d && out_pred == prev_p, "R10 hold",
                          out_data, prev_d);
                    vec++;
                end
            end
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule